// File: doc/BRIEF.md
# Raster-Gated Processor Run Enable

This block decides, clock by clock, whether a processor core that shares time with a video generator may advance. It watches the raster position (the current line number plus separate horizontal and vertical blanking flags) and a small mode register that the processor writes through a simple write port. The result is a single enable bit that the core samples on every clock.

Software picks how much of the visible picture the processor may steal. The choices are: blanking only; blanking plus a quarter, a half or three quarters of the visible lines; or no gating at all. The permitted visible lines are picked from the two low bits of the line number. By default they are spread evenly over each group of four lines. A build option packs them at the start of each group instead. A newly written mode waits until the line number changes, so a mode change never takes effect in the middle of a line.

Top module: `vgate_run_ctrl`

## Requirements
- R1: After reset the committed mode is code 1, so run_en equals (hblank OR vblank) until a new mode has been committed.
- R2: Under codes 1, 2, 3 and 4, run_en is high in every cycle where hblank or vblank is high.
- R3: Under code 2, on a visible cycle (both blanking flags low), run_en is high only when line_num[1:0] == 0.
- R4: Under code 3, on a visible cycle, run_en is high only when line_num[1:0] is 0 or 2.
- R5: Under code 4, on a visible cycle, run_en is high when line_num[1:0] is 0, 1 or 2, and low when it is 3.
- R6: Under code 0, run_en is high in every cycle, whatever the raster inputs are.
- R7: Codes 5, 6 and 7 behave exactly as code 1, so run_en is high only while a blanking flag is set.
- R8: A value written with cfg_wr is latched at that clock edge as the pending mode. The pending mode governs run_en from the first cycle in which line_num differs from its value on the previous cycle. Until that cycle, the mode that was already in force still applies.
- R9: When several writes fall within one line, only the last one takes effect at the next line change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_wdata | input | 3 | Mode code to write (0 ungated, 1 to 4 gated, 5 to 7 treated as 1) |
| line_num | input | LINE_W | Current raster line; visible lines start at 0 |
| hblank | input | 1 | Horizontal blanking flag |
| vblank | input | 1 | Vertical blanking flag |
| run_en | output | 1 | Processor run enable |

## Verification
The key corner case is a write that lands in the middle of a visible line. A design that commits the mode at once lets run_en rise partway through that line. A design that commits one cycle late produces the wrong value in the first cycle of the next line. The bench also writes more than once inside one line, and writes in the same cycle as a line change. The first catches a design that keeps the first write instead of the last. The second catches a design that drops or applies a write at the boundary. Reserved codes, and line indices 1 and 3 under the half and three-quarter modes, expose decoders that swap the fractions or treat unknown codes as ungated.

// File: rtl/vgate_pkg.sv
package vgate_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      GM_FREE = 3'd0,
      GM_SYNC = 3'd1,
      GM_QTR  = 3'd2,
      GM_HALF = 3'd3,
      GM_3QTR = 3'd4
   } gmode_e;

   // Number of visible lines (out of each group of four) a mode grants.
   // 4 means the raster is ignored entirely.
   function automatic logic [2:0] mode_quarters(input logic [MODE_W-1:0] code);
      case (code)
         3'd0:    mode_quarters = 3'd4;
         3'd2:    mode_quarters = 3'd1;
         3'd3:    mode_quarters = 3'd2;
         3'd4:    mode_quarters = 3'd3;
         default: mode_quarters = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/vgate_mode_reg.sv
module vgate_mode_reg
   import vgate_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [MODE_W-1:0] wdata_i,
   input  logic              line_start_i,
   output logic [MODE_W-1:0] mode_eff_o
);

   logic [MODE_W-1:0] pending_q;
   logic [MODE_W-1:0] active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= GM_SYNC;
         active_q  <= GM_SYNC;
      end else begin
         if (wr_i)
            pending_q <= wdata_i;
         if (line_start_i)
            active_q <= pending_q;
      end
   end

   // The first cycle of a new line already uses the pending value.
   assign mode_eff_o = line_start_i ? pending_q : active_q;

   AST_COMMIT_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      line_start_i |=> active_q == $past(pending_q)) else $error("commit"); // R8
   AST_HOLD_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start_i |=> $stable(active_q)) else $error("hold"); // R8
   AST_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> pending_q == $past(wdata_i)) else $error("last write"); // R9

endmodule

// File: rtl/vgate_line_select.sv
module vgate_line_select
   import vgate_pkg::*;
#(
   parameter bit SPREAD_EVEN = 1'b1
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic              blank_i,
   input  logic [1:0]        idx_i,
   output logic              grant_o
);

   logic [2:0] quarters;
   logic       line_ok;

   assign quarters = mode_quarters(mode_i);

   generate
      if (SPREAD_EVEN) begin : g_even
         always_comb begin
            case (quarters)
               3'd1:    line_ok = (idx_i == 2'd0);
               3'd2:    line_ok = !idx_i[0];
               3'd3:    line_ok = (idx_i != 2'd3);
               3'd4:    line_ok = 1'b1;
               default: line_ok = 1'b0;
            endcase
         end
      end else begin : g_packed
         always_comb line_ok = ({1'b0, idx_i} < quarters);
      end
   endgenerate

   assign grant_o = blank_i | line_ok;

endmodule

// File: rtl/vgate_run_ctrl.sv
module vgate_run_ctrl
   import vgate_pkg::*;
#(
   parameter int ACTIVE_LINES = 480,
   parameter int TOTAL_LINES  = 525,
   parameter bit SPREAD_EVEN  = 1'b1,
   localparam int LINE_W      = $clog2(TOTAL_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [MODE_W-1:0] cfg_wdata,
   input  logic [LINE_W-1:0] line_num,
   input  logic              hblank,
   input  logic              vblank,
   output logic              run_en
);

   generate
      if (ACTIVE_LINES % 4 != 0) begin : g_bad_active
         $error("ACTIVE_LINES must be a multiple of four");
      end
      if (TOTAL_LINES <= ACTIVE_LINES) begin : g_bad_total
         $error("TOTAL_LINES must exceed ACTIVE_LINES");
      end
   endgenerate

   logic [LINE_W-1:0] line_q;
   logic              line_start;
   logic [MODE_W-1:0] mode_eff;
   logic              blank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= line_num;
   end

   assign line_start = (line_num != line_q);
   assign blank      = hblank | vblank;

   vgate_mode_reg u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (cfg_wr),
      .wdata_i      (cfg_wdata),
      .line_start_i (line_start),
      .mode_eff_o   (mode_eff)
   );

   vgate_line_select #(.SPREAD_EVEN(SPREAD_EVEN)) u_sel (
      .mode_i  (mode_eff),
      .blank_i (blank),
      .idx_i   (line_num[1:0]),
      .grant_o (run_en)
   );

   AST_BLANK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> run_en) else $error("blank"); // R2
   AST_FREE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_eff == GM_FREE) |-> run_en) else $error("free"); // R6
   AST_LINE3_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!blank && line_num[1:0] == 2'd3 && mode_eff != GM_FREE) |-> !run_en)
      else $error("idx3"); // R5
   AST_RESERVED_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (!blank && mode_eff > GM_3QTR) |-> !run_en) else $error("reserved"); // R7

endmodule

// File: tb/vgate_run_ctrl_tb.sv
module vgate_run_ctrl_tb_top;

   localparam int ACT   = 12;
   localparam int TOT   = 16;
   localparam int LW    = $clog2(TOT);
   localparam int LLEN  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [2:0]    cfg_wdata = 3'd0;
   logic [LW-1:0] line_num = '0;
   logic          hblank = 1'b0;
   logic          vblank = 1'b0;
   logic          run_en;

   int n_chk = 0;
   int n_bad = 0;
   logic [2:0]    m_pend = 3'd1;
   logic [2:0]    m_act  = 3'd1;
   logic [LW-1:0] m_prev = '0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   vgate_run_ctrl #(.ACTIVE_LINES(ACT), .TOTAL_LINES(TOT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .line_num(line_num), .hblank(hblank), .vblank(vblank), .run_en(run_en));

   function automatic logic exp_en(input logic [2:0] m, input logic b, input logic [1:0] i);
      if (m == 3'd0) return 1'b1;
      if (b) return 1'b1;
      case (m)
         3'd2:    return i == 2'd0;
         3'd3:    return i[0] == 1'b0;
         3'd4:    return i != 2'd3;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] m, input logic b);
      if (m == 3'd0) return "R6";
      if (m > 3'd4)  return "R7";
      if (b)         return "R2";
      case (m)
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         default: return "R1";
      endcase
   endfunction

   task automatic check(input logic e, input string tag);
      n_chk++;
      if (run_en !== e) begin
         n_bad++;
         $display("FAIL %s: run_en=%0b expected %0b (line %0d hb %0b vb %0b)",
                  tag, run_en, e, line_num, hblank, vblank);
      end
   endtask

   // One clock: drive at the falling edge, check before the rising edge,
   // then advance the model as the design will at that rising edge.
   task automatic step(input bit wr, input logic [2:0] wd, input logic [LW-1:0] ln,
                       input logic hb, input logic vb, input string tag);
      logic [2:0] eff;
      @(negedge clk);
      cfg_wr = wr; cfg_wdata = wd; line_num = ln; hblank = hb; vblank = vb;
      #5;
      eff = (ln != m_prev) ? m_pend : m_act;
      check(exp_en(eff, hb | vb, ln[1:0]), (tag == "") ? req_of(eff, hb | vb) : tag);
      if (ln != m_prev) m_act = m_pend;
      if (wr) m_pend = wd;
      m_prev = ln;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset mode, visible and blanked cycles
      step(0, 0, 4'd0, 0, 0, "R1");
      step(0, 0, 4'd0, 1, 0, "R1");
      step(0, 0, 4'd0, 0, 1, "R1");

      // R8: ungated write mid-line on line 1 stays ineffective until line 2
      step(0, 0, 4'd1, 0, 0, "R8");
      step(1, 3'd0, 4'd1, 0, 0, "R8");
      step(0, 0, 4'd1, 0, 0, "R8");
      step(0, 0, 4'd1, 0, 0, "R8");
      step(0, 0, 4'd2, 0, 0, "R8");
      step(0, 0, 4'd3, 0, 0, "R6");

      // R9: two writes in one line, last (quarter) wins
      step(1, 3'd4, 4'd3, 0, 0, "R9");
      step(1, 3'd2, 4'd3, 0, 0, "R9");
      step(0, 0, 4'd4, 0, 0, "R9");
      step(0, 0, 4'd5, 0, 0, "R9");

      // R8: write in the same cycle as a line change waits one more line
      step(1, 3'd3, 4'd6, 0, 0, "R8");
      step(0, 0, 4'd6, 0, 0, "R8");
      step(0, 0, 4'd7, 0, 0, "R4");
      step(0, 0, 4'd8, 0, 0, "R4");

      // R7: reserved code
      step(1, 3'd6, 4'd8, 0, 0, "R7");
      step(0, 0, 4'd9, 0, 0, "R7");
      step(0, 0, 4'd9, 1, 0, "R7");

      // Random raster with occasional writes
      for (int fr = 0; fr < 20; fr++) begin
         for (int ln = 0; ln < TOT; ln++) begin
            for (int px = 0; px < LLEN; px++) begin
               bit w = ($urandom % 10) == 0;
               step(w, 3'($urandom % 8), LW'(ln), px >= LLEN - 2, ln >= ACT, "");
            end
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule